// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four independent pulse-width-modulated outputs. Software sets each channel through a small word-addressed register bus. Every channel has a 16-bit prescaler, which divides the input clock into ticks. A 16-bit period divider counts those ticks to make one output period. A 16-bit high-duration count sets how many ticks at the start of each period the output stays high. Outputs use normal polarity: high first, then low.

All settings land in shadow copies when they are written, and the running counters do not see them. Writing the update bit asks for a transfer. A stopped channel takes the new settings on the next clock. A running channel waits until its current period ends, so it never emits a truncated or stretched pulse. The enable bit moves across with the same transfer. The update bit stays readable as 1 until the transfer has happened.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low and every register reads zero.
- R2: Channel c owns word addresses 2c (configuration word) and 2c+1 (control word). The configuration word carries the high-duration count in bits 31:16 and the period divider in bits 15:0. The control word carries the prescaler in bits 15:0, the update request in bit 30 and the enable in bit 31. A read returns the shadow values on `bus_rdata` after the clock edge that samples `bus_rd`, and `bus_rdata` holds its value while no read is made.
- R3: Writes change only the shadow settings. Without an update request, the output of every channel is unaffected.
- R4: The update bit reads 1 from the edge that accepts the request until the edge that transfers the settings, and reads 0 after that.
- R5: On a channel whose running enable is clear, a request transfers the settings at the next clock edge.
- R6: On a running channel, a request transfers the settings only at the edge that ends the current period, so the counters restart at zero with the new values.
- R7: A running channel repeats with a period of (prescaler+1)*(divider+1) clock cycles.
- R8: Within each period, the output is high for the first high_count*(prescaler+1) cycles and low for the rest.
- R9: When the high count is greater than the divider, the output stays high for the whole period.
- R10: A channel whose running enable is clear drives its output low and holds its counters at zero. Clearing enable takes effect through an update request, at the end of the current period.
- R11: The channels run independently: a write or a transfer on one channel does not alter the output of another.
- R12: A high count of zero keeps a running channel's output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all counters |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address of the register |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable, sampled at the rising edge |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A write is sampled at edge E. A stopped channel transfers its settings at E+1, and its output changes in the half cycle that follows. A running channel transfers at the edge that closes its period, and the read data is due one edge after `bus_rd` is sampled. The bench runs a behavioural model on the same edges, using a period-position counter rather than the design's two counters. It compares all four outputs and any pending read result at every falling edge, so each result is checked exactly in the cycle it is due. Directed checks also measure high time and period at the pins.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int CW      = 16;  // counter / field width
    localparam int DW      = 32;  // bus data width
    localparam int HI_LSB  = 16;  // high count in config word
    localparam int DIV_LSB = 0;   // divider in config word
    localparam int PRE_LSB = 0;   // prescaler in control word
    localparam int UPD_BIT = 30;  // update request
    localparam int EN_BIT  = 31;  // enable

    typedef struct packed {
        logic          en;
        logic [CW-1:0] pre;
        logic [CW-1:0] div;
        logic [CW-1:0] hi;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
    import pwm_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cfg,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    input  logic          boundary_i,
    output pwm_cfg_t      shadow_o,
    output pwm_cfg_t      active_o,
    output logic          pend_o
);
    typedef struct packed {
        pwm_cfg_t shd;
        pwm_cfg_t act;
        logic     pend;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     load;

    always_comb begin
        st_d = st_q;
        load = st_q.pend && (!st_q.act.en || boundary_i);
        if (load) begin
            st_d.act  = st_q.shd;
            st_d.pend = 1'b0;
        end
        if (wr_cfg) begin
            st_d.shd.hi  = wdata[HI_LSB +: CW];
            st_d.shd.div = wdata[DIV_LSB +: CW];
        end
        if (wr_ctl) begin
            st_d.shd.pre = wdata[PRE_LSB +: CW];
            st_d.shd.en  = wdata[EN_BIT];
            if (wdata[UPD_BIT]) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o = st_q.shd;
    assign active_o = st_q.act;
    assign pend_o   = st_q.pend;

    // a stopped channel never keeps a request past one edge
    assert_stopped_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !st_q.act.en && !(wr_ctl && wdata[UPD_BIT])) |=> !st_q.pend);

    // a running channel keeps its settings until its period ends
    assert_hold_mid_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act.en && !boundary_i) |=> $stable(st_q.act));

    // update bit stays set until a transfer happens
    assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.act.en && !boundary_i) |=> st_q.pend);
endmodule

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer
    import pwm_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pwm_cfg_t cfg_i,
    output logic     boundary_o,
    output logic     pwm_o
);
    typedef struct packed {
        logic [CW-1:0] pre_cnt;
        logic [CW-1:0] per_cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    pre_end, per_end;

    always_comb begin
        pre_end = (st_q.pre_cnt == cfg_i.pre);
        per_end = (st_q.per_cnt == cfg_i.div);
        st_d    = st_q;
        if (!cfg_i.en) begin
            st_d = '0;
        end else if (pre_end) begin
            st_d.pre_cnt = '0;
            st_d.per_cnt = per_end ? '0 : st_q.per_cnt + 1'b1;
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boundary_o = cfg_i.en && pre_end && per_end;
    assign pwm_o      = cfg_i.en && (st_q.per_cnt < cfg_i.hi);

    assert_cnt_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (st_q.pre_cnt == '0 && st_q.per_cnt == '0));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.en |-> (st_q.pre_cnt <= cfg_i.pre && st_q.per_cnt <= cfg_i.div));

    assert_full_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && cfg_i.hi > cfg_i.div) |-> pwm_o);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int AW  = $clog2(2 * NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_rd,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } bus_st_t;

    bus_st_t       st_d, st_q;
    logic [DW-1:0] cfg_word [NCH];
    logic [DW-1:0] ctl_word [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm_cfg_t shd, act;
        logic     pend, bnd, wr_cfg, wr_ctl;

        assign wr_cfg = bus_wr && (bus_addr == AW'(2 * ch));
        assign wr_ctl = bus_wr && (bus_addr == AW'(2 * ch + 1));

        pwm_chan_ctrl u_ctrl (
            .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_ctl(wr_ctl),
            .wdata(bus_wdata), .boundary_i(bnd),
            .shadow_o(shd), .active_o(act), .pend_o(pend)
        );

        pwm_chan_timer u_tmr (
            .clk(clk), .rst_n(rst_n), .cfg_i(act),
            .boundary_o(bnd), .pwm_o(pwm_out[ch])
        );

        always_comb begin
            cfg_word[ch]                 = '0;
            cfg_word[ch][HI_LSB +: CW]   = shd.hi;
            cfg_word[ch][DIV_LSB +: CW]  = shd.div;
            ctl_word[ch]                 = '0;
            ctl_word[ch][PRE_LSB +: CW]  = shd.pre;
            ctl_word[ch][UPD_BIT]        = pend;
            ctl_word[ch][EN_BIT]         = shd.en;
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = '0;
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr[AW-1:1] == (AW-1)'(c))
                    st_d.rdata = bus_addr[0] ? ctl_word[c] : cfg_word[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    always #5 clk = ~clk;

    pwm_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    mon_on = 0;
    bit    done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: shadow, active, pending, position within period
    int s_hi[4], s_div[4], s_pre[4], s_en[4];
    int a_hi[4], a_div[4], a_pre[4], a_en[4];
    int pend[4], pos[4];
    bit rd_chk = 0;
    longint exp_rd = 0;

    function automatic bit exp_out(int c);
        int h;
        h = (a_hi[c] < a_div[c] + 1) ? a_hi[c] : a_div[c] + 1;
        return (a_en[c] != 0) && (pos[c] < h * (a_pre[c] + 1));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                s_hi[c] = 0; s_div[c] = 0; s_pre[c] = 0; s_en[c] = 0;
                a_hi[c] = 0; a_div[c] = 0; a_pre[c] = 0; a_en[c] = 0;
                pend[c] = 0; pos[c] = 0;
            end
        end else begin
            if (bus_rd) begin
                int c;
                c = bus_addr / 2;
                if (bus_addr % 2 == 0) exp_rd = (longint'(s_hi[c]) << 16) | s_div[c];
                else exp_rd = (longint'(s_en[c]) << 31) | (longint'(pend[c] != 0) << 30) | s_pre[c];
                rd_chk = 1;
            end
            for (int c = 0; c < 4; c++) begin
                int  per;
                bit  ld;
                per = (a_pre[c] + 1) * (a_div[c] + 1);
                ld  = (pend[c] != 0) && (a_en[c] == 0 || pos[c] == per - 1);
                if (a_en[c] != 0 && !ld) pos[c] = (pos[c] == per - 1) ? 0 : pos[c] + 1;
                else pos[c] = 0;
                if (ld) begin
                    a_hi[c] = s_hi[c]; a_div[c] = s_div[c];
                    a_pre[c] = s_pre[c]; a_en[c] = s_en[c]; pend[c] = 0;
                end
            end
            if (bus_wr) begin
                int c;
                c = bus_addr / 2;
                if (bus_addr % 2 == 0) begin
                    s_hi[c] = bus_wdata[31:16]; s_div[c] = bus_wdata[15:0];
                end else begin
                    s_pre[c] = bus_wdata[15:0]; s_en[c] = bus_wdata[31];
                    if (bus_wdata[30]) pend[c] = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            for (int c = 0; c < 4; c++)
                chk(pwm_out[c] === exp_out(c), cur_req, $sformatf("pwm_out[%0d]", c),
                    pwm_out[c], exp_out(c));
            if (rd_chk) begin
                chk(bus_rdata === exp_rd[31:0], cur_req, "read data", bus_rdata, exp_rd);
                rd_chk = 0;
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        bus_addr = a[2:0]; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a);
        bus_addr = a[2:0]; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] cfgw(int hi, int dv);
        return {hi[15:0], dv[15:0]};
    endfunction

    function automatic logic [31:0] ctlw(bit en, bit upd, int pre);
        return {en, upd, 14'b0, pre[15:0]};
    endfunction

    task automatic measure(int c, int eh, int ep, string req);
        int h = 0, l = 0, g = 0;
        while (pwm_out[c] !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
        while (pwm_out[c] !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
        while (pwm_out[c] === 1'b1 && g < 2000) begin h++; @(negedge clk); g++; end
        while (pwm_out[c] === 1'b0 && g < 2000) begin l++; @(negedge clk); g++; end
        chk(h == eh, req, $sformatf("high cycles ch%0d", c), h, eh);
        chk(h + l == ep, req, $sformatf("period ch%0d", c), h + l, ep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pwm_out === 4'b0, "R1", "outputs in reset", pwm_out, 0);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        // R1: all registers zero after reset
        cur_req = "R1";
        for (int a = 0; a < 8; a++) rd(a);

        // R2 / R3: shadow writes, readback, no effect on outputs
        cur_req = "R2";
        wr(2, cfgw(5, 9));
        rd(2);
        wr(5, ctlw(1, 0, 7));
        rd(5);
        cur_req = "R3";
        repeat (20) @(negedge clk);
        chk(pwm_out === 4'b0, "R3", "outputs without update", pwm_out, 0);

        // R5: stopped channel loads on the next edge
        cur_req = "R5";
        wr(0, cfgw(2, 3));
        wr(1, ctlw(1, 1, 1));
        chk(pwm_out[0] === 1'b0, "R5", "before transfer", pwm_out[0], 0);
        @(negedge clk);
        chk(pwm_out[0] === 1'b1, "R5", "after transfer", pwm_out[0], 1);
        // R7 / R8: prescaler 1, divider 3, high 2 -> high 4 of 8
        cur_req = "R8";
        measure(0, 4, 8, "R8");
        measure(0, 4, 8, "R7");

        // R4 / R6: running channel waits for its period end
        cur_req = "R6";
        wr(0, cfgw(1, 5));
        wr(1, ctlw(1, 1, 0));
        cur_req = "R4";
        rd(1);
        cur_req = "R6";
        repeat (12) @(negedge clk);
        cur_req = "R4";
        rd(1);
        cur_req = "R7";
        measure(0, 1, 6, "R7");

        // R9: high count above divider
        cur_req = "R9";
        wr(6, cfgw(9, 3));
        wr(7, ctlw(1, 1, 2));
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            chk(pwm_out[3] === 1'b1, "R9", "full high", pwm_out[3], 1);
            @(negedge clk);
        end

        // R12: zero high count
        cur_req = "R12";
        wr(2, cfgw(0, 4));
        wr(3, ctlw(1, 1, 0));
        for (int i = 0; i < 25; i++) begin
            chk(pwm_out[1] === 1'b0, "R12", "zero high", pwm_out[1], 0);
            @(negedge clk);
        end

        // R3: new shadow values on a running channel without update
        cur_req = "R3";
        wr(6, cfgw(1, 7));
        repeat (40) @(negedge clk);
        rd(6);

        // R11: all channels running different settings
        cur_req = "R11";
        wr(4, cfgw(3, 6));
        wr(5, ctlw(1, 1, 2));
        wr(2, cfgw(2, 2));
        wr(3, ctlw(1, 1, 1));
        wr(7, ctlw(1, 1, 1));
        repeat (300) @(negedge clk);

        // R10: disable through update at period end, then restart
        cur_req = "R10";
        wr(1, ctlw(0, 1, 0));
        repeat (10) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk(pwm_out[0] === 1'b0, "R10", "disabled low", pwm_out[0], 0);
            @(negedge clk);
        end
        wr(1, ctlw(1, 1, 0));
        cur_req = "R10";
        repeat (40) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule